// File: doc/BRIEF.md
# Multicast Cell Write Admission Controller

This block sits on the write side of a cell buffer that fans one input stream out to four destination queues. A 5-bit destination address picks one queue or any group of them. The block raises a cell-available flag only when every chosen queue can take a whole cell. It then accepts a cell as a run of 16-bit words, each qualified by a write enable, with a start-of-cell marker on the first word. For every accepted word it produces per-queue write strobes in the same cycle, so the queue memories capture the word on the edge where the enable is sampled.

Space is reserved per cell. When a cell is admitted, the full storage of that cell is added at once to each chosen queue's level. Each level counts 9-bit entries, and each queue holds 128 of them. A cell of B bytes takes 2*ceil(B/2) entries, because an odd cell carries a padding byte in the low half of its last word. Because of this reservation, cell-available falls in the cycle after a start-of-cell whenever the queue cannot take a further cell. That is well before the last word of the current cell. A read side outside this block returns space through per-queue pop strobes.

Top module: `cell_admit_top`

## Requirements
- R1: After reset, every queue level is 0, no cell is open, no write strobe is active, and cell-available is high for any non-empty selection.
- R2: When address bit 4 is 0, the selection is the single queue numbered by address bits 1:0, and bits 3:2 have no effect. When bit 4 is 1, the selection mask is address bits 3:0. An empty mask keeps cell-available low.
- R3: Cell-available is high exactly when the mask is non-empty and, for every selected queue, 128 minus its level is at least 2*ceil(B/2). Here B is the programmed cell byte count, valid from 16 to 128.
- R4: A word with write enable and start-of-cell, while no cell is open and cell-available is high, opens a cell. In that same cycle the write strobes equal the selection mask. On the next edge each selected level grows by 2*ceil(B/2).
- R5: While a cell is open, every enabled word is strobed to the mask latched at admission. Address changes have no effect, and a start-of-cell marker is treated as plain data. The cell closes after ceil(B/2) words.
- R6: With no cell open, an enabled word without start-of-cell is discarded. This includes words that follow a completed cell: all write strobes stay 0.
- R7: A start-of-cell word that arrives while cell-available is low is discarded. All strobes stay 0, all levels stay unchanged, and no cell opens.
- R8: The padding flag is high only on the last word of a cell whose B is odd. The reservation for an odd cell includes the padding byte, so it is B+1 entries.
- R9: A pop strobe lowers its queue's level by one entry on the next edge. A pop is ignored when the level is 0. A pop that coincides with a reservation gives the net sum.
- R10: When a queue cannot hold another cell after the current one, cell-available for that queue is low from the cycle after the start-of-cell. That is at least four cycles before the last word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cellBytes | input | 8 | Programmed cell length in bytes (16 to 128) |
| addr | input | 5 | Destination address: bit 4 selects multicast; see R2 |
| wrEn | input | 1 | Word write enable |
| soc | input | 1 | Start-of-cell marker for the first word |
| wrData | input | 16 | Input word |
| deq | input | 4 | Per-queue pop strobes from the read side, one entry each |
| cellAvail | output | 1 | All selected queues can take a whole cell |
| qWrite | output | 4 | Per-queue write strobes for the current word |
| qData | output | 16 | Word to be written into the strobed queues |
| qPad | output | 1 | Low byte of this word is padding |
| qLevel | output | 32 | Four 8-bit queue levels in entries, queue 0 in bits 7:0 |

## Verification
The hardest state to reach is a queue filled to within a fraction of one cell. That state must be held there so that cell-available can be seen at the exact boundary. The stimulus first streams complete odd-length cells into one queue until its level is 126. It then pops single entries and samples the flag at a level of 111, where it must be low, and at 110, where it must be high. On the cell that brings the queue near full, the flag is sampled in the cycle after start-of-cell while words are still pending. A start-of-cell on the saturated queue, and a multicast selection that includes it, then show the refusal and the gating.

// File: rtl/cell_admit_pkg.sv
`timescale 1ns/1ps
package cell_admit_pkg;
  localparam int NQ = 4;

  typedef struct packed {
    logic          reserve;
    logic [NQ-1:0] mask;
  } admit_strobe_t;
endpackage

// File: rtl/cell_admit_dp.sv
`timescale 1ns/1ps
module cell_admit_dp
  import cell_admit_pkg::*;
#(
  parameter int DEPTH  = 128,
  parameter int ADDR_W = 5,
  parameter int SIZE_W = 8,
  localparam int LVL_W = $clog2(DEPTH + 1),
  localparam int IDX_W = $clog2(NQ)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [SIZE_W-1:0]   cellBytes,
  input  logic [NQ-1:0]       deq,
  input  admit_strobe_t       strobe,
  output logic [NQ-1:0]       selMask,
  output logic                cellAvail,
  output logic [NQ*LVL_W-1:0] levelFlat
);
  logic [SIZE_W:0]  byteRound;
  logic [31:0]      cellEntries;
  logic [LVL_W-1:0] level [NQ];
  logic [NQ-1:0]    roomOk;

  // entries per cell: bytes rounded up to whole 16-bit words
  assign byteRound   = {1'b0, cellBytes} + 1'b1;
  assign cellEntries = 32'({byteRound[SIZE_W:1], 1'b0});

  always_comb begin
    if (addr[ADDR_W-1]) selMask = addr[NQ-1:0];
    else                selMask = NQ'(1) << addr[IDX_W-1:0];
  end

  for (genvar q = 0; q < NQ; q++) begin : g_queue
    logic [31:0] freeSpace;
    logic [31:0] addAmt;
    logic        popOk;

    assign freeSpace = 32'(DEPTH) - 32'(level[q]);
    assign roomOk[q] = !selMask[q] || (freeSpace >= cellEntries);
    assign addAmt    = (strobe.reserve && strobe.mask[q]) ? cellEntries : 32'd0;
    assign popOk     = deq[q] && (level[q] != '0);
    assign levelFlat[q*LVL_W +: LVL_W] = level[q];

    always_ff @(posedge clk) begin
      if (!rst_n) level[q] <= '0;
      else        level[q] <= LVL_W'(32'(level[q]) + addAmt - 32'(popOk));
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      32'(level[q]) <= 32'(DEPTH)); // R3

    AST_POP_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
      (level[q] == '0 && !(strobe.reserve && strobe.mask[q])) |=> level[q] == '0); // R9
  end

  assign cellAvail = (selMask != '0) && (&roomOk);

  AST_EMPTY_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (selMask == '0) |-> !cellAvail); // R2
endmodule

// File: rtl/cell_admit_ctrl.sv
`timescale 1ns/1ps
module cell_admit_ctrl
  import cell_admit_pkg::*;
#(
  parameter int SIZE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SIZE_W-1:0] cellBytes,
  input  logic              wrEn,
  input  logic              soc,
  input  logic              cellAvail,
  input  logic [NQ-1:0]     selMask,
  output admit_strobe_t     strobe,
  output logic [NQ-1:0]     qWrite,
  output logic              qPad
);
  logic              inCell;
  logic [NQ-1:0]     curMask;
  logic [SIZE_W-1:0] wordCnt;
  logic [SIZE_W:0]   byteRound;
  logic [SIZE_W-1:0] cellWords;
  logic              accept;
  logic              midWrite;
  logic              lastWord;

  assign byteRound = {1'b0, cellBytes} + 1'b1;
  assign cellWords = byteRound[SIZE_W:1];

  assign accept   = !inCell && wrEn && soc && cellAvail;
  assign midWrite = inCell && wrEn;
  assign lastWord = (accept && cellWords == SIZE_W'(1)) ||
                    (midWrite && (wordCnt + SIZE_W'(1)) == cellWords);

  assign strobe.reserve = accept;
  assign strobe.mask    = selMask;
  assign qWrite = accept ? selMask : (midWrite ? curMask : '0);
  assign qPad   = lastWord && cellBytes[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      inCell  <= 1'b0;
      curMask <= '0;
      wordCnt <= '0;
    end else if (accept) begin
      curMask <= selMask;
      wordCnt <= SIZE_W'(1);
      inCell  <= (cellWords != SIZE_W'(1));
    end else if (midWrite) begin
      wordCnt <= wordCnt + SIZE_W'(1);
      if (lastWord) inCell <= 1'b0;
    end
  end

  AST_OPEN_ON_SOC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(inCell) |-> $past(wrEn && soc && cellAvail)); // R4

  AST_MASK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (inCell && $past(inCell)) |-> $stable(curMask)); // R5

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!inCell && !soc) |-> qWrite == '0); // R6

  AST_ADMIT_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
    (!inCell && qWrite != '0) |-> cellAvail); // R7

  AST_PAD_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    qPad |-> (qWrite != '0) && cellBytes[0]); // R8
endmodule

// File: rtl/cell_admit_top.sv
`timescale 1ns/1ps
module cell_admit_top
  import cell_admit_pkg::*;
#(
  parameter int DEPTH  = 128,
  parameter int ADDR_W = 5,
  parameter int SIZE_W = 8,
  parameter int DATA_W = 16,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SIZE_W-1:0]   cellBytes,
  input  logic [ADDR_W-1:0]   addr,
  input  logic                wrEn,
  input  logic                soc,
  input  logic [DATA_W-1:0]   wrData,
  input  logic [NQ-1:0]       deq,
  output logic                cellAvail,
  output logic [NQ-1:0]       qWrite,
  output logic [DATA_W-1:0]   qData,
  output logic                qPad,
  output logic [NQ*LVL_W-1:0] qLevel
);
  admit_strobe_t strobe;
  logic [NQ-1:0] selMask;

  cell_admit_ctrl #(.SIZE_W(SIZE_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cellBytes(cellBytes), .wrEn(wrEn), .soc(soc),
    .cellAvail(cellAvail), .selMask(selMask), .strobe(strobe),
    .qWrite(qWrite), .qPad(qPad)
  );

  cell_admit_dp #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .addr(addr), .cellBytes(cellBytes), .deq(deq),
    .strobe(strobe), .selMask(selMask), .cellAvail(cellAvail), .levelFlat(qLevel)
  );

  assign qData = wrData;
endmodule

// File: tb/cell_admit_top_bench.sv
`timescale 1ns/1ps
module cell_admit_top_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  cellBytes = 8'd17;
  logic [4:0]  addr = '0;
  logic        wrEn = 1'b0;
  logic        soc = 1'b0;
  logic [15:0] wrData = '0;
  logic [3:0]  deq = '0;
  logic        cellAvail;
  logic [3:0]  qWrite;
  logic [15:0] qData;
  logic        qPad;
  logic [31:0] qLevel;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  cell_admit_top u_cell_admit_top (
    .clk(clk), .rst_n(rst_n), .cellBytes(cellBytes), .addr(addr), .wrEn(wrEn),
    .soc(soc), .wrData(wrData), .deq(deq), .cellAvail(cellAvail),
    .qWrite(qWrite), .qData(qData), .qPad(qPad), .qLevel(qLevel)
  );

  // {addr[4:0], wrEn, expected cellAvail}; soc low, so no strobe expected
  localparam logic [6:0] VEC [6] = '{
    {5'b00000, 1'b0, 1'b1},
    {5'b00011, 1'b1, 1'b1},
    {5'b11111, 1'b0, 1'b1},
    {5'b10000, 1'b0, 1'b0},
    {5'b01110, 1'b1, 1'b1},
    {5'b10000, 1'b1, 1'b0}
  };

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int lvl(input int q);
    return int'(qLevel[q*8 +: 8]);
  endfunction

  task automatic idle();
    @(negedge clk);
    wrEn = 1'b0; soc = 1'b0; deq = '0;
    #1;
  endtask

  task automatic sendCell(input logic [4:0] a, input logic [3:0] mask, input int words, input bit odd);
    for (int i = 0; i < words; i++) begin
      @(negedge clk);
      addr = (i == 0) ? a : ~a;   // later address changes must not matter
      wrEn = 1'b1;
      soc  = (i == 0 || i == 3);  // mid-cell marker is plain data
      wrData = 16'(i * 3 + 1);
      #1;
      chk("R5 strobe follows latched mask", qWrite, mask);
      chk("R8 pad flag on last odd word", qPad, (odd && i == words - 1));
    end
    idle();
    addr = a;
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1; #1;
    // R1: reset state
    for (int q = 0; q < 4; q++) chk("R1 level after reset", lvl(q), 0);
    chk("R1 no strobe after reset", qWrite, 0);
    chk("R1 avail after reset", cellAvail, 1);

    // R2 / R6 table walk
    foreach (VEC[k]) begin
      @(negedge clk);
      addr = VEC[k][6:2]; wrEn = VEC[k][1]; soc = 1'b0;
      #1;
      chk("R2 decode avail", cellAvail, VEC[k][0]);
      chk("R6 no strobe without soc", qWrite, 0);
    end
    idle();

    // R9: pop on empty queues is ignored
    @(negedge clk); deq = 4'b1111; #1;
    idle();
    for (int q = 0; q < 4; q++) chk("R9 pop at zero ignored", lvl(q), 0);

    // R4 + R2: unicast to queue 2, bits 3:2 ignored in unicast (addr 01110 -> q2)
    @(negedge clk); addr = 5'b01110; wrEn = 1'b1; soc = 1'b1; #1;
    chk("R4 admit strobe unicast q2", qWrite, 4'b0100);
    @(negedge clk); wrEn = 1'b0; soc = 1'b0; #1;
    chk("R4 reservation q2 odd cell", lvl(2), 18);
    chk("R8 reservation includes pad", lvl(2), 17 + 1);
    // finish remaining 8 words
    for (int i = 1; i < 9; i++) begin
      @(negedge clk); addr = 5'b00001; wrEn = 1'b1; soc = (i == 4); #1;
      chk("R5 mid-cell strobe q2", qWrite, 4'b0100);
      chk("R8 pad only on last", qPad, (i == 8));
    end
    @(negedge clk); wrEn = 1'b1; soc = 1'b0; #1;
    chk("R6 write after cell end discarded", qWrite, 0);
    idle();
    chk("R6 level unchanged", lvl(1), 0);

    // multicast q0 + q2
    sendCell(5'b10101, 4'b0101, 9, 1'b1);
    chk("R4 multicast q0 level", lvl(0), 18);
    chk("R4 multicast q2 level", lvl(2), 36);

    // even cell on q1: 8 words, no pad
    cellBytes = 8'd16;
    sendCell(5'b00001, 4'b0010, 8, 1'b0);
    chk("R8 even cell reservation", lvl(1), 16);
    cellBytes = 8'd17;

    // fill queue 3
    for (int c = 0; c < 6; c++) sendCell(5'b00011, 4'b1000, 9, 1'b1);
    chk("R3 q3 level after six cells", lvl(3), 108);
    chk("R3 avail with room 20", cellAvail, 1);
    @(negedge clk); addr = 5'b00011; wrEn = 1'b1; soc = 1'b1; #1;
    chk("R4 seventh cell admitted", qWrite, 4'b1000);
    @(negedge clk); wrEn = 1'b0; soc = 1'b0; #1;
    chk("R10 avail low after soc", cellAvail, 0);
    chk("R10 level 126", lvl(3), 126);
    for (int i = 1; i < 9; i++) begin
      @(negedge clk); wrEn = 1'b1; #1;
      if (i <= 4) chk("R10 avail low before last word", cellAvail, 0);
    end
    idle();

    // refused start-of-cell
    @(negedge clk); addr = 5'b00011; wrEn = 1'b1; soc = 1'b1; #1;
    chk("R7 refused soc no strobe", qWrite, 0);
    idle();
    chk("R7 level unchanged", lvl(3), 126);
    @(negedge clk); wrEn = 1'b1; soc = 1'b0; #1;
    chk("R7 no cell opened", qWrite, 0);
    idle();

    // multicast gating
    addr = 5'b11001; #1;
    chk("R3 multicast with full q3", cellAvail, 0);
    addr = 5'b10011; #1;
    chk("R3 multicast q0 q1", cellAvail, 1);
    addr = 5'b00011;

    // drain q3 to the boundary
    for (int p = 0; p < 15; p++) begin
      @(negedge clk); deq = 4'b1000;
    end
    idle();
    chk("R9 pops lower level", lvl(3), 111);
    chk("R3 room 17 insufficient", cellAvail, 0);
    @(negedge clk); deq = 4'b1000;
    idle();
    chk("R3 room 18 sufficient", cellAvail, 1);

    // concurrent reserve and pop
    @(negedge clk); addr = 5'b00011; wrEn = 1'b1; soc = 1'b1; deq = 4'b1000; #1;
    chk("R4 admit at boundary", qWrite, 4'b1000);
    @(negedge clk); wrEn = 1'b0; soc = 1'b0; deq = 4'b0000; #1;
    chk("R9 net reserve and pop", lvl(3), 127);
    for (int i = 1; i < 9; i++) begin
      @(negedge clk); wrEn = 1'b1; #1;
    end
    idle();
    chk("R5 cell closed after words", qWrite, 0);

    finish();
  end
endmodule